// File: doc/BRIEF.md
# Dot-Matrix LCD Refresh Scanner

This block refreshes a passive dot-matrix LCD panel without pause from an external display RAM. It walks the RAM address and reads two bytes for each character cell. The first byte feeds the upper half of the panel and the second, taken at a fixed offset, feeds the lower half. The block shifts both bytes out in parallel on two serial dot lines. A shift clock drives the column drivers. A single-cycle latch pulse closes every row, and a frame marker flags the first row of each frame. A duty setting chooses how many rows each half scans before the frame starts again.

In graphic mode every RAM bit is one dot, and the address runs linearly through the whole frame. In character mode the RAM byte is taken to be the glyph dot row returned by an external character generator. The four top address bits carry the glyph line index. The same cell addresses are replayed once for each glyph line before the scan moves on to the next text row. A horizontal pitch register sets how many dots of each byte reach the panel. It comes out of reset at 6.

Top module: `lcd_scan_top`

## Requirements
- R1: Each cell takes one RAM byte at the upper address A and one at A + `lo_off`. The RAM has one cycle of read latency. The upper byte goes out on `dot_up` and the lower byte on `dot_lo`, one bit per rising edge of `sclk`, and both dot lines hold steady while `sclk` is high.
- R2: Bits leave most significant first. Exactly `pitch` bits of each byte are sent, and the low 8 − `pitch` bits are dropped.
- R3: The pitch register holds 6 after reset. A write with `pitch_we` high loads `pitch_din` only when the value lies between 6 and 8. Any other value leaves the register unchanged.
- R4: After the last bit of a row, `line_latch` is high for exactly one cycle. Each row carries (`cells_m1`+1)×`pitch` bits. A frame holds `duty_m1`+1 rows.
- R5: `frame_mark` is high through the shifting of row 0 and during its latch pulse, and low for all other rows. With `duty_m1` = 0 it stays high on every row.
- R6: In graphic mode (`char_mode` = 0), row r, cell c reads address `start_addr` + r×(`cells_m1`+1) + c, modulo 2^16. The address reloads `start_addr` at each frame start.
- R7: In character mode, address bits 15:12 carry the glyph line g. Line 0 is the first, and the line count runs to `glyph_m1`. For text row t the low 12 bits are (`start_addr` + t×(`cells_m1`+1) + c) mod 2^12, and the lower half adds `lo_off`[11:0] modulo 2^12. The glyph line restarts at 0 at each frame start.
- R8: While `disp_on` is low, and during reset, `sclk`, `dot_up`, `dot_lo`, `line_latch` and `frame_mark` are 0 from the second cycle on. The scan restarts at row 0, cell 0 when the display is switched back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_on | input | 1 | Display enable; low holds the scanner in its start state |
| char_mode | input | 1 | 1 = character mode, 0 = graphic mode |
| pitch_we | input | 1 | Write strobe for the pitch register |
| pitch_din | input | 4 | New pitch value (accepted when 6..8) |
| cells_m1 | input | 8 | Cells per row minus one |
| duty_m1 | input | 7 | Rows per half-frame minus one |
| glyph_m1 | input | 4 | Glyph lines per text row minus one |
| start_addr | input | 16 | Frame start address |
| lo_off | input | 16 | Offset from upper-half to lower-half address |
| mem_rdata | input | 8 | RAM read data, one cycle after the address |
| mem_addr | output | 16 | RAM read address |
| sclk | output | 1 | Dot shift clock for the column drivers |
| dot_up | output | 1 | Serial dots for the upper half |
| dot_lo | output | 1 | Serial dots for the lower half |
| line_latch | output | 1 | Row latch pulse |
| frame_mark | output | 1 | Frame marker, high during row 0 |

## Verification
The hardest cases to reach from the ports are the wrap conditions. These are the 16-bit address wrap in graphic mode, the 12-bit wrap of the cell address below the glyph index in character mode, and a frame whose row count is not a multiple of the glyph line count, so the glyph line has to reset in mid text row. The stimulus places `start_addr` just below each wrap point and chooses `duty_m1` = 4 with three glyph lines. The RAM model returns bytes that are a function of all 16 address bits, so a wrong glyph index or a wrong wrap shows up directly in the serial dots. A display-off pulse in mid-frame checks that the scan restarts from row 0.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [2:0] {
    ST_START   = 3'd0,
    ST_FETCH_U = 3'd1,
    ST_FETCH_L = 3'd2,
    ST_LOAD    = 3'd3,
    ST_SHIFT   = 3'd4,
    ST_LATCH   = 3'd5
  } scan_st_t;
endpackage

// File: rtl/lcd_pitch_reg.sv
module lcd_pitch_reg #(
  parameter int PITCH_W   = 4,
  parameter int PITCH_DEF = 6,
  parameter int PITCH_MIN = 6,
  parameter int PITCH_MAX = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [PITCH_W-1:0] din,
  output logic [PITCH_W-1:0] pitch
);
  localparam logic [PITCH_W-1:0] P_DEF = PITCH_W'(PITCH_DEF);
  localparam logic [PITCH_W-1:0] P_MIN = PITCH_W'(PITCH_MIN);
  localparam logic [PITCH_W-1:0] P_MAX = PITCH_W'(PITCH_MAX);

  logic [PITCH_W-1:0] pitch_q;

  always_ff @(posedge clk) begin
    if (rst)
      pitch_q <= P_DEF;
    else if (we && din >= P_MIN && din <= P_MAX)
      pitch_q <= din;
  end

  assign pitch = pitch_q;

  AST_PITCH_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (pitch_q >= P_MIN && pitch_q <= P_MAX)); // R3
  AST_PITCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (we && (din < P_MIN || din > P_MAX)) |=> $stable(pitch_q)); // R3
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CELL_W  = 8,
  parameter int ROW_W   = 7,
  parameter int GL_W    = 4,
  parameter int PITCH_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               disp_on,
  input  logic               char_mode,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [CELL_W-1:0]  cells_m1,
  input  logic [ROW_W-1:0]   duty_m1,
  input  logic [GL_W-1:0]    glyph_m1,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [ADDR_W-1:0]  lo_off,
  output scan_st_t           st,
  output logic               ph,
  output logic               row_zero,
  output logic [ADDR_W-1:0]  mem_addr
);
  localparam int LOW_W = ADDR_W - GL_W;

  scan_st_t            st_q, st_n;
  logic                ph_q, ph_n;
  logic [PITCH_W-1:0]  bit_q, bit_n;
  logic [CELL_W-1:0]   cell_q, cell_n;
  logic [ROW_W-1:0]    row_q, row_n;
  logic [GL_W-1:0]     gl_q, gl_n;
  logic [ADDR_W-1:0]   ptr_q, ptr_n, base_q, base_n;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic [LOW_W-1:0]    low_sum;

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    bit_n  = bit_q;
    cell_n = cell_q;
    row_n  = row_q;
    gl_n   = gl_q;
    ptr_n  = ptr_q;
    base_n = base_q;
    if (!disp_on) begin
      st_n   = ST_START;
      ph_n   = 1'b0;
      bit_n  = '0;
      cell_n = '0;
      row_n  = '0;
      gl_n   = '0;
    end else begin
      unique case (st_q)
        ST_START: begin
          st_n   = ST_FETCH_U;
          ptr_n  = start_addr;
          base_n = start_addr;
        end
        ST_FETCH_U: st_n = ST_FETCH_L;
        ST_FETCH_L: st_n = ST_LOAD;
        ST_LOAD: begin
          st_n  = ST_SHIFT;
          ph_n  = 1'b0;
          bit_n = '0;
        end
        ST_SHIFT: begin
          if (!ph_q) begin
            ph_n = 1'b1;
          end else begin
            ph_n = 1'b0;
            if (bit_q == pitch - 1'b1) begin
              bit_n = '0;
              if (cell_q == cells_m1) begin
                st_n = ST_LATCH;
              end else begin
                cell_n = cell_q + 1'b1;
                ptr_n  = ptr_q + 1'b1;
                st_n   = ST_FETCH_U;
              end
            end else begin
              bit_n = bit_q + 1'b1;
            end
          end
        end
        ST_LATCH: begin
          st_n   = ST_FETCH_U;
          cell_n = '0;
          if (row_q == duty_m1) begin
            row_n  = '0;
            gl_n   = '0;
            ptr_n  = start_addr;
            base_n = start_addr;
          end else begin
            row_n = row_q + 1'b1;
            if (char_mode && gl_q != glyph_m1) begin
              gl_n  = gl_q + 1'b1;
              ptr_n = base_q;
            end else begin
              gl_n   = '0;
              ptr_n  = ptr_q + 1'b1;
              base_n = ptr_q + 1'b1;
            end
          end
        end
        default: st_n = ST_START;
      endcase
    end
  end

  // Address for the next cycle, from next-state values, so mem_addr is a flop.
  always_comb begin
    low_sum = ptr_n[LOW_W-1:0] + lo_off[LOW_W-1:0];
    if (char_mode) begin
      if (st_n == ST_FETCH_L) addr_n = {gl_n, low_sum};
      else                    addr_n = {gl_n, ptr_n[LOW_W-1:0]};
    end else begin
      if (st_n == ST_FETCH_L) addr_n = ptr_n + lo_off;
      else                    addr_n = ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_START;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      cell_q <= '0;
      row_q  <= '0;
      gl_q   <= '0;
      ptr_q  <= '0;
      base_q <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      cell_q <= cell_n;
      row_q  <= row_n;
      gl_q   <= gl_n;
      ptr_q  <= ptr_n;
      base_q <= base_n;
      addr_q <= addr_n;
    end
  end

  assign st       = st_q;
  assign ph       = ph_q;
  assign row_zero = (row_q == '0);
  assign mem_addr = addr_q;

  AST_LO_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FETCH_L && !char_mode && $stable(char_mode) && $stable(lo_off))
      |-> addr_q == $past(addr_q) + lo_off); // R1
  AST_GLYPH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FETCH_L && char_mode && $stable(char_mode))
      |-> addr_q[ADDR_W-1:LOW_W] == $past(addr_q[ADDR_W-1:LOW_W])); // R7
endmodule

// File: rtl/lcd_dot_shifter.sv
module lcd_dot_shifter
  import lcd_scan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  scan_st_t          st,
  input  logic              ph,
  input  logic              row_zero,
  input  logic [DATA_W-1:0] rdata,
  output logic              sclk,
  output logic              dot_up,
  output logic              dot_lo,
  output logic              latch,
  output logic              frame
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sh_u, sh_l;
  logic sclk_q, du_q, dl_q, latch_q, frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_u <= '0;
      sh_l <= '0;
    end else begin
      if (st == ST_FETCH_L) sh_u <= rdata;
      if (st == ST_LOAD)    sh_l <= rdata;
      if (st == ST_SHIFT && ph) begin
        sh_u <= {sh_u[MSB-1:0], 1'b0};
        sh_l <= {sh_l[MSB-1:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      du_q    <= 1'b0;
      dl_q    <= 1'b0;
      latch_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      sclk_q  <= (st == ST_SHIFT) && ph;
      du_q    <= (st == ST_SHIFT) && sh_u[MSB];
      dl_q    <= (st == ST_SHIFT) && sh_l[MSB];
      latch_q <= (st == ST_LATCH);
      frame_q <= (st != ST_START) && row_zero;
    end
  end

  assign sclk   = sclk_q;
  assign dot_up = du_q;
  assign dot_lo = dl_q;
  assign latch  = latch_q;
  assign frame  = frame_q;

  AST_DOTS_STEADY: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> ($stable(du_q) && $stable(dl_q))); // R1
  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    latch_q |=> !latch_q); // R4
  AST_LATCH_NO_CLK: assert property (@(posedge clk) disable iff (rst)
    latch_q |-> !sclk_q); // R4
endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top
  import lcd_scan_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int CELL_W  = 8,
  parameter int ROW_W   = 7,
  parameter int GL_W    = 4,
  parameter int PITCH_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               disp_on,
  input  logic               char_mode,
  input  logic               pitch_we,
  input  logic [PITCH_W-1:0] pitch_din,
  input  logic [CELL_W-1:0]  cells_m1,
  input  logic [ROW_W-1:0]   duty_m1,
  input  logic [GL_W-1:0]    glyph_m1,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [ADDR_W-1:0]  lo_off,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               sclk,
  output logic               dot_up,
  output logic               dot_lo,
  output logic               line_latch,
  output logic               frame_mark
);
  logic [PITCH_W-1:0] pitch;
  scan_st_t           st;
  logic               ph;
  logic               row_zero;

  lcd_pitch_reg #(.PITCH_W(PITCH_W)) u_pitch (
    .clk(clk), .rst(rst), .we(pitch_we), .din(pitch_din), .pitch(pitch)
  );

  lcd_scan_seq #(
    .ADDR_W(ADDR_W), .CELL_W(CELL_W), .ROW_W(ROW_W), .GL_W(GL_W), .PITCH_W(PITCH_W)
  ) u_seq (
    .clk(clk), .rst(rst), .disp_on(disp_on), .char_mode(char_mode), .pitch(pitch),
    .cells_m1(cells_m1), .duty_m1(duty_m1), .glyph_m1(glyph_m1),
    .start_addr(start_addr), .lo_off(lo_off),
    .st(st), .ph(ph), .row_zero(row_zero), .mem_addr(mem_addr)
  );

  lcd_dot_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .st(st), .ph(ph), .row_zero(row_zero), .rdata(mem_rdata),
    .sclk(sclk), .dot_up(dot_up), .dot_lo(dot_lo), .latch(line_latch), .frame(frame_mark)
  );

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(disp_on) && !$past(disp_on, 2))
      |-> !(sclk || dot_up || dot_lo || line_latch || frame_mark)); // R8
endmodule

// File: tb/lcd_scan_top_bench.sv
module lcd_scan_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        disp_on = 1'b0;
  logic        char_mode = 1'b0;
  logic        pitch_we = 1'b0;
  logic [3:0]  pitch_din = '0;
  logic [7:0]  cells_m1 = '0;
  logic [6:0]  duty_m1 = '0;
  logic [3:0]  glyph_m1 = '0;
  logic [15:0] start_addr = '0;
  logic [15:0] lo_off = '0;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr;
  logic        sclk, dot_up, dot_lo, line_latch, frame_mark;

  always #2 clk = ~clk;

  lcd_scan_top u_lcd_scan_top (
    .clk(clk), .rst(rst), .disp_on(disp_on), .char_mode(char_mode),
    .pitch_we(pitch_we), .pitch_din(pitch_din), .cells_m1(cells_m1),
    .duty_m1(duty_m1), .glyph_m1(glyph_m1), .start_addr(start_addr),
    .lo_off(lo_off), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .sclk(sclk), .dot_up(dot_up), .dot_lo(dot_lo),
    .line_latch(line_latch), .frame_mark(frame_mark)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ (a[15:8] * 8'd11) ^ 8'h5A;
  endfunction

  // Synchronous RAM model, one cycle read latency
  always @(posedge clk) mem_rdata <= memf(mem_addr);

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";
  logic [1:0] bitq[$];
  bit         rowq[$];
  int  exp_bits = 0;
  int  bits_in_row = 0;
  bit  mon_on = 1'b0;
  bit  sclk_d = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: expected dot pairs and per-row frame flags
  task automatic build(input bit cm, input int hp, input int rows);
    bitq.delete();
    rowq.delete();
    exp_bits = (int'(cells_m1) + 1) * hp;
    for (int i = 0; i < rows; i++) begin
      int r = i % (int'(duty_m1) + 1);
      int g = cm ? r % (int'(glyph_m1) + 1) : 0;
      int t = cm ? r / (int'(glyph_m1) + 1) : r;
      for (int c = 0; c <= int'(cells_m1); c++) begin
        logic [15:0] p, ua, la, ps;
        logic [7:0] bu, bl;
        p  = start_addr + 16'(t * (int'(cells_m1) + 1) + c);
        ps = p + lo_off;
        ua = cm ? {4'(g), p[11:0]}  : p;
        la = cm ? {4'(g), ps[11:0]} : ps;
        bu = memf(ua);
        bl = memf(la);
        for (int b = 0; b < hp; b++) bitq.push_back({bu[7-b], bl[7-b]});
      end
      rowq.push_back(r == 0);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (sclk && !sclk_d) begin
        if (bitq.size() == 0 || rowq.size() == 0) begin
          chk(1'b0, tag, "extra shift clock", 1, 0);
        end else begin
          logic [1:0] e;
          e = bitq.pop_front();
          chk(dot_up == e[1], tag, "dot_up (R1/R2)", dot_up, e[1]);
          chk(dot_lo == e[0], tag, "dot_lo (R1/R2)", dot_lo, e[0]);
          chk(frame_mark == rowq[0], "R5", "frame_mark during row", frame_mark, rowq[0]);
        end
        bits_in_row++;
      end
      if (line_latch) begin
        chk(bits_in_row == exp_bits, "R4", "bits per row", bits_in_row, exp_bits);
        if (rowq.size() == 0) begin
          chk(1'b0, "R4", "extra latch", 1, 0);
        end else begin
          bit f;
          f = rowq.pop_front();
          chk(frame_mark == f, "R5", "frame_mark at latch", frame_mark, f);
        end
        bits_in_row = 0;
        if (rowq.size() == 0) mon_on = 1'b0;
      end
    end
    sclk_d = sclk;
  end

  task automatic quiet_check(input string req);
    for (int i = 0; i < 3; i++) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!(sclk || dot_up || dot_lo || line_latch || frame_mark), req,
          "outputs while off", {sclk, dot_up, dot_lo, line_latch, frame_mark}, 0);
    end
  endtask

  task automatic run(input string t, input bit cm, input int hp, input int rows);
    int guard;
    tag = t;
    char_mode = cm;
    build(cm, hp, rows);
    bits_in_row = 0;
    mon_on = 1'b1;
    disp_on = 1'b1;
    guard = 0;
    while (mon_on && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    if (mon_on) begin
      chk(1'b0, t, "watchdog expired", guard, 0);
      mon_on = 1'b0;
    end
    chk(bitq.size() == 0, t, "bits left over", bitq.size(), 0);
    disp_on = 1'b0;
    quiet_check("R8");
  endtask

  task automatic wr_pitch(input logic [3:0] v);
    @(negedge clk);
    pitch_we = 1'b1;
    pitch_din = v;
    @(negedge clk);
    pitch_we = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!(sclk || dot_up || dot_lo || line_latch || frame_mark), "R8",
        "outputs in reset", {sclk, dot_up, dot_lo, line_latch, frame_mark}, 0);
    rst = 1'b0;
    quiet_check("R8");

    // R6 graphic, default pitch 6 (R3)
    cells_m1 = 8'd2; duty_m1 = 7'd3; start_addr = 16'h0100; lo_off = 16'h0040;
    run("R3", 1'b0, 6, 8);

    // R3: legal write then illegal writes ignored; R6 with 16-bit wrap
    wr_pitch(4'd8);
    wr_pitch(4'd5);
    wr_pitch(4'd9);
    cells_m1 = 8'd1; duty_m1 = 7'd2; start_addr = 16'hFFFE; lo_off = 16'h8000;
    run("R6", 1'b0, 8, 6);

    // R8 mid-frame disable, then a full restart from row 0
    cells_m1 = 8'd1; duty_m1 = 7'd3; start_addr = 16'h0300; lo_off = 16'h0010;
    run("R8", 1'b0, 8, 2);
    run("R8", 1'b0, 8, 4);

    // R7 character mode, 12-bit wrap, duty not a multiple of glyph lines
    wr_pitch(4'd7);
    cells_m1 = 8'd1; duty_m1 = 7'd4; glyph_m1 = 4'd2;
    start_addr = 16'h0FFF; lo_off = 16'h0800;
    run("R7", 1'b1, 7, 10);

    // R5 static duty: frame marker on every row
    cells_m1 = 8'd0; duty_m1 = 7'd0; start_addr = 16'h2000; lo_off = 16'h0001;
    run("R5", 1'b0, 7, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule